// File: doc/BRIEF.md
# Bidirectional Port Function Decoder

This block turns the control pins of one 36-bit bidirectional port of a dual-port FIFO with mailboxes into qualified operation strobes. The control pins are an active-low chip select, a write/read select, an enable and a mailbox select. The block also takes the two handshake flags: input-ready and output-ready. While the port clock runs, at most one of four strobes is high: FIFO write, mailbox write, FIFO read or mailbox read. A strobe is high only when the next rising edge would commit that operation. The strobes are combinational, so the storage logic samples them on that rising edge.

The block also makes the output-enable for the tri-state data pads. It routes either the FIFO output register or the mailbox register onto the outgoing data word. The sense of the write/read select is set by a parameter, so one decoder serves both ports: on one port a high level means write, and on the other port a low level means write. The FIFO storage, the flags and the synchronizers are outside this block.

Internally the select pins are first reduced to a direction state: idle, write or read. A unique case over that state picks the operation: none, FIFO write, mailbox write, FIFO read or mailbox read.

Top module: `bidir_port_decoder`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` is 0 and the write/read select is in its read state. It is 0 whenever `cs_n` is 1 or the select is in its write state.
- R2: `bus_oe` depends only on `cs_n` and `wr_rd_sel`. `en`, `mbox_sel`, `in_ready` and `out_ready` have no effect on it.
- R3: `fifo_wr` is 1 only when all of these hold: `rst_n` is 1, `cs_n` is 0, the select is in its write state, `en` is 1, `mbox_sel` is 0 and `in_ready` is 1.
- R4: `fifo_rd` is 1 only when all of these hold: `rst_n` is 1, `cs_n` is 0, the select is in its read state, `en` is 1, `mbox_sel` is 0 and `out_ready` is 1.
- R5: `mbox_wr` is 1 exactly when `rst_n` is 1, `cs_n` is 0, the select is in its write state, `en` is 1 and `mbox_sel` is 1. The ready flags play no part.
- R6: `mbox_rd` is 1 exactly when `rst_n` is 1, `cs_n` is 0, the select is in its read state, `en` is 1 and `mbox_sel` is 1. The ready flags play no part.
- R7: When `en` is 0, all four strobes are 0, whatever `cs_n` and `wr_rd_sel` are.
- R8: At most one of `fifo_wr`, `mbox_wr`, `fifo_rd` and `mbox_rd` is 1 in any cycle.
- R9: While `bus_oe` is 1, `bus_out` equals `fifo_q` when `mbox_sel` is 0 and equals `mbox_q` when `mbox_sel` is 1, whether or not `en` is 1. While `bus_oe` is 0, `bus_out` is all zeros.
- R10: With `WR_SEL_INVERT` = 0, `wr_rd_sel` = 1 is the write state and 0 is the read state. With `WR_SEL_INVERT` = 1 the meaning is swapped: 0 is write and 1 is read.
- R11: While `rst_n` is 0, all four strobes are 0. `bus_oe` and `bus_out` keep following R1 and R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; operations commit on its rising edge |
| rst_n | input | 1 | Active-low reset; masks all strobes |
| cs_n | input | 1 | Port chip select, active low |
| wr_rd_sel | input | 1 | Write/read select, polarity set by `WR_SEL_INVERT` |
| en | input | 1 | Port enable, active high |
| mbox_sel | input | 1 | 1 selects the mailbox, 0 selects the FIFO |
| in_ready | input | 1 | FIFO has room for a write |
| out_ready | input | 1 | FIFO output register holds valid data |
| fifo_q | input | DATA_W | FIFO output register contents |
| mbox_q | input | DATA_W | Mailbox register contents |
| fifo_wr | output | 1 | FIFO write strobe |
| mbox_wr | output | 1 | Mailbox write strobe |
| fifo_rd | output | 1 | FIFO read strobe |
| mbox_rd | output | 1 | Mailbox read strobe |
| bus_oe | output | 1 | Output-enable for the tri-state data pads |
| bus_out | output | DATA_W | Word presented to the data pads |

## Verification
On every clock the assertions check four things:
- At most one strobe is high.
- The enable gates all operations.
- A FIFO write needs input-ready and a FIFO read needs output-ready.
- The output-enable never coincides with a write, stays steady while the chip select and write/read select stay steady, and routes the mailbox word when the mailbox is selected.

Two things are shown only by the bench. Its exhaustive sweep of all 64 pin combinations, with reset released and held, on both polarities of the parameter, shows that each strobe appears in exactly the intended combination. Only that sweep also shows that the inverted-polarity instance swaps write and read correctly.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    // Direction implied by chip select and write/read select
    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_WRITE = 2'd1,
        DIR_READ  = 2'd2
    } port_dir_e;

    // Operation committed by the next rising port clock edge
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_FIFO_WR = 3'd1,
        OP_MBOX_WR = 3'd2,
        OP_FIFO_RD = 3'd3,
        OP_MBOX_RD = 3'd4
    } port_op_e;

endpackage

// File: rtl/bpd_dir_decode.sv
module bpd_dir_decode
    import bpd_pkg::*;
#(
    parameter bit WR_SEL_INVERT = 1'b0
) (
    input  logic      cs_n,
    input  logic      wr_rd_sel,
    output port_dir_e dir,
    output logic      bus_oe
);

    logic sel_is_write;

    // Polarity variant picked by parameter
    generate
        if (WR_SEL_INVERT) begin : g_low_writes
            assign sel_is_write = ~wr_rd_sel;
        end else begin : g_high_writes
            assign sel_is_write = wr_rd_sel;
        end
    endgenerate

    always_comb begin
        if (cs_n)
            dir = DIR_IDLE;
        else if (sel_is_write)
            dir = DIR_WRITE;
        else
            dir = DIR_READ;
    end

    // Pads drive only in the read direction; no other input involved
    assign bus_oe = (dir == DIR_READ);

endmodule

// File: rtl/bpd_op_select.sv
module bpd_op_select
    import bpd_pkg::*;
(
    input  logic      rst_n,
    input  port_dir_e dir,
    input  logic      en,
    input  logic      mbox_sel,
    input  logic      in_ready,
    input  logic      out_ready,
    output port_op_e  op
);

    always_comb begin
        op = OP_NONE;
        if (rst_n && en) begin
            unique case (dir)
                DIR_IDLE:  op = OP_NONE;
                DIR_WRITE: begin
                    if (mbox_sel)      op = OP_MBOX_WR;
                    else if (in_ready) op = OP_FIFO_WR;
                    else               op = OP_NONE;
                end
                DIR_READ: begin
                    if (mbox_sel)       op = OP_MBOX_RD;
                    else if (out_ready) op = OP_FIFO_RD;
                    else                op = OP_NONE;
                end
                default:   op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bpd_route.sv
module bpd_route #(
    parameter int DATA_W = 36
) (
    input  logic              bus_oe,
    input  logic              mbox_sel,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mbox_q,
    output logic [DATA_W-1:0] bus_out
);

    localparam logic [DATA_W-1:0] IDLE_WORD = '0;

    always_comb begin
        if (!bus_oe)
            bus_out = IDLE_WORD;
        else if (mbox_sel)
            bus_out = mbox_q;
        else
            bus_out = fifo_q;
    end

endmodule

// File: rtl/bidir_port_decoder.sv
module bidir_port_decoder
    import bpd_pkg::*;
#(
    parameter int DATA_W        = 36,
    parameter bit WR_SEL_INVERT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_rd_sel,
    input  logic              en,
    input  logic              mbox_sel,
    input  logic              in_ready,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mbox_q,
    output logic              fifo_wr,
    output logic              mbox_wr,
    output logic              fifo_rd,
    output logic              mbox_rd,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_out
);

    port_dir_e dir;
    port_op_e  op;

    bpd_dir_decode #(.WR_SEL_INVERT(WR_SEL_INVERT)) u_dir (
        .cs_n      (cs_n),
        .wr_rd_sel (wr_rd_sel),
        .dir       (dir),
        .bus_oe    (bus_oe)
    );

    bpd_op_select u_op (
        .rst_n     (rst_n),
        .dir       (dir),
        .en        (en),
        .mbox_sel  (mbox_sel),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .op        (op)
    );

    bpd_route #(.DATA_W(DATA_W)) u_route (
        .bus_oe   (bus_oe),
        .mbox_sel (mbox_sel),
        .fifo_q   (fifo_q),
        .mbox_q   (mbox_q),
        .bus_out  (bus_out)
    );

    // Output process: one strobe per operation
    always_comb begin
        fifo_wr = 1'b0;
        mbox_wr = 1'b0;
        fifo_rd = 1'b0;
        mbox_rd = 1'b0;
        unique case (op)
            OP_NONE:    ;
            OP_FIFO_WR: fifo_wr = 1'b1;
            OP_MBOX_WR: mbox_wr = 1'b1;
            OP_FIFO_RD: fifo_rd = 1'b1;
            OP_MBOX_RD: mbox_rd = 1'b1;
            default:    ;
        endcase
    end

    // Assertions
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, mbox_wr, fifo_rd, mbox_rd}));

    assert_no_op_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(fifo_wr || mbox_wr || fifo_rd || mbox_rd));

    assert_fifo_wr_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (in_ready && !mbox_sel && !cs_n && !bus_oe));

    assert_fifo_rd_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (out_ready && !mbox_sel && bus_oe));

    assert_no_write_while_driving_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !(fifo_wr || mbox_wr));

    assert_oe_follows_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cs_n) && $stable(wr_rd_sel)) |-> $stable(bus_oe));

    assert_mbox_routed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && mbox_sel) |-> (bus_out == mbox_q));

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R11: assert (!(fifo_wr || mbox_wr || fifo_rd || mbox_rd));
        end
    end

endmodule

// File: tb/test_bidir_port_decoder.sv
module test_bidir_port_decoder;

    localparam int DATA_W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_rd_sel = 1'b0, en = 1'b0, mbox_sel = 1'b0;
    logic in_ready = 1'b0, out_ready = 1'b0;
    logic [DATA_W-1:0] fifo_q = '0, mbox_q = '0;

    logic a_fw, a_mw, a_fr, a_mr, a_oe;
    logic b_fw, b_mw, b_fr, b_mr, b_oe;
    logic [DATA_W-1:0] a_bus, b_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bidir_port_decoder #(.DATA_W(DATA_W), .WR_SEL_INVERT(1'b0)) i_bidir_port_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd_sel(wr_rd_sel), .en(en),
        .mbox_sel(mbox_sel), .in_ready(in_ready), .out_ready(out_ready),
        .fifo_q(fifo_q), .mbox_q(mbox_q),
        .fifo_wr(a_fw), .mbox_wr(a_mw), .fifo_rd(a_fr), .mbox_rd(a_mr),
        .bus_oe(a_oe), .bus_out(a_bus)
    );

    bidir_port_decoder #(.DATA_W(DATA_W), .WR_SEL_INVERT(1'b1)) i_bidir_port_decoder_inv (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd_sel(wr_rd_sel), .en(en),
        .mbox_sel(mbox_sel), .in_ready(in_ready), .out_ready(out_ready),
        .fifo_q(fifo_q), .mbox_q(mbox_q),
        .fifo_wr(b_fw), .mbox_wr(b_mw), .fifo_rd(b_fr), .mbox_rd(b_mr),
        .bus_oe(b_oe), .bus_out(b_bus)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cs_n=%b sel=%b en=%b mb=%b ir=%b or=%b rst_n=%b)",
                     req, act, exp, cs_n, wr_rd_sel, en, mbox_sel, in_ready, out_ready, rst_n);
        end
    endtask

    // Compare one instance against values computed from the requirements
    task automatic check_port(input bit inv, input logic oe, input logic fw, input logic mw,
                              input logic fr, input logic mr, input logic [DATA_W-1:0] bus);
        logic wr_state, exp_oe, act_ok;
        logic [DATA_W-1:0] exp_bus;
        wr_state = inv ? ~wr_rd_sel : wr_rd_sel;                // R10
        exp_oe   = ~cs_n & ~wr_state;                           // R1
        act_ok   = rst_n & ~cs_n & en;                          // R7, R11
        exp_bus  = exp_oe ? (mbox_sel ? mbox_q : fifo_q) : '0;  // R9
        check(inv ? "R1 R2 R10 oe(inv)" : "R1 R2 oe", 64'(oe), 64'(exp_oe));
        check("R3 R7 R11 fifo_wr", 64'(fw), 64'(act_ok & wr_state & ~mbox_sel & in_ready));
        check("R5 R7 R11 mbox_wr", 64'(mw), 64'(act_ok & wr_state & mbox_sel));
        check("R4 R7 R11 fifo_rd", 64'(fr), 64'(act_ok & ~wr_state & ~mbox_sel & out_ready));
        check("R6 R7 R11 mbox_rd", 64'(mr), 64'(act_ok & ~wr_state & mbox_sel));
        check("R8 one strobe", 64'($countones({fw, mw, fr, mr}) <= 1), 64'd1);
        check("R9 bus_out", 64'(bus), 64'(exp_bus));
    endtask

    initial begin
        // Reset state: strobes quiet, nothing driven with cs_n high
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset a", 64'({a_fw, a_mw, a_fr, a_mr, a_oe}), 64'd0);
        check("R11 reset b", 64'({b_fw, b_mw, b_fr, b_mr, b_oe}), 64'd0);

        // Sweep every pin combination, first under reset, then released
        for (int phase = 0; phase < 2; phase++) begin
            for (int v = 0; v < 64; v++) begin
                @(negedge clk);
                rst_n     = (phase == 1);
                {cs_n, wr_rd_sel, en, mbox_sel, in_ready, out_ready} = 6'(v);
                fifo_q    = 36'h0A5A5_0000 + 36'(v);
                mbox_q    = 36'hF0F00_0000 + 36'(v * 3);
                #1;
                check_port(1'b0, a_oe, a_fw, a_mw, a_fr, a_mr, a_bus);
                check_port(1'b1, b_oe, b_fw, b_mw, b_fr, b_mr, b_bus);
            end
        end

        // R2: toggling en, mbox_sel and flags with selects held leaves bus_oe unchanged
        @(negedge clk);
        cs_n = 1'b0; wr_rd_sel = 1'b0;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            {en, mbox_sel, in_ready, out_ready} = 4'(v);
            #1;
            check("R2 oe held a", 64'(a_oe), 64'd1);
            check("R2 oe held b", 64'(b_oe), 64'd0);
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule